// File: doc/BRIEF.md
# 64-bit Alarm Timer with Coherent Count Snapshot

This block is a free-running 64-bit up-counter behind a 32-bit register port. Software starts and stops it with a run bit. A tick-enable input gates each increment, so a slower time base can be supplied from outside. The count cannot be read directly. A write to a trigger register copies the live count into a pair of 32-bit snapshot registers. Software then reads the upper and lower words at leisure, and the value does not tear while the counter moves on.

A 64-bit alarm value is programmed as two 32-bit words. When the alarm is armed and the count reaches or exceeds it, the alarm fires. Firing sets a sticky raw interrupt bit and disarms the alarm, so it acts only once until software arms it again. If auto-reload is selected, the counter is loaded with a programmable 64-bit reload value on the firing edge. The interrupt output is a level. It is the OR of the raw bits gated by an enable mask, and the mask is changed through separate set and clear registers.

Register map (4-bit word address): 0x0 control, 0x1 snapshot trigger, 0x2/0x3 snapshot low/high, 0x4/0x5 alarm low/high, 0x6/0x7 reload low/high, 0x8 mask set (reads the mask), 0x9 mask clear, 0xA raw status, 0xB status clear. Addresses that cannot be read, and addresses outside the map, read as 0.

Top module: `alarm_timer64`

## Requirements
- R1: With control bit 0 (run) at 1, the counter adds 1 on every clock edge at which `tick_en` is 1. It holds its value when run is 0 or `tick_en` is 0. It carries from the low 32 bits into the high 32 bits.
- R2: Any write to address 0x1 copies the count present in that cycle into the snapshot. Address 0x2 reads the low word and 0x3 the high word. The snapshot keeps its value until the next write to 0x1, even while the counter runs.
- R3: The alarm value is written and read back as a low word at 0x4 and a high word at 0x5.
- R4: The control register at 0x0 holds run in bit 0, auto-reload in bit 1 and alarm-arm in bit 2, and reads back those three bits.
- R5: While armed, the alarm fires in any cycle in which the count is greater than or equal to the alarm value, including a count already past it when the alarm is armed. On firing, the arm bit (0x0 bit 2) returns to 0.
- R6: When the alarm fires with auto-reload set, the counter takes the 64-bit reload value (low word 0x6, high word 0x7, 0 after reset) on that same edge instead of incrementing. Without auto-reload it keeps counting.
- R7: Firing sets raw status bit 0 (read at 0xA), whatever the mask. The bit stays at 1 until it is cleared.
- R8: A write to 0xB clears each raw status bit written as 1 and leaves bits written as 0 unchanged. A set and a clear in the same cycle leave the bit at 1.
- R9: A write to 0x8 ORs the write data into the enable mask, and a write to 0x9 removes the bits written as 1. `irq` is 1 exactly when some raw bit and its mask bit are both 1.
- R10: After reset, control, count, snapshot, alarm, reload, mask and raw status are all 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | Count qualifier; the counter steps only on edges where it is 1 |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt: masked raw status ORed together |

## Verification
A register write takes effect on the edge that ends its strobe cycle. Read data is combinational, so it shows the new value in the next cycle. The count moves on each qualified edge. The alarm compares the registered count, so a count that reaches the alarm on edge k makes the alarm fire on edge k+1; the raw bit, the disarm and any reload all land on that edge, and `irq` follows combinationally. The bench drives every input on a falling edge and samples on a falling edge after the edge that should have acted. It brackets tick activity with an exact number of rising edges, so each expected count is a plain sum that includes the one-edge alarm delay.

// File: rtl/alarm_timer64_pkg.sv
package alarm_timer64_pkg;

  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL    = 4'h0,
    A_SNAP    = 4'h1,
    A_SNAP_LO = 4'h2,
    A_SNAP_HI = 4'h3,
    A_ALM_LO  = 4'h4,
    A_ALM_HI  = 4'h5,
    A_RLD_LO  = 4'h6,
    A_RLD_HI  = 4'h7,
    A_IEN_SET = 4'h8,
    A_IEN_CLR = 4'h9,
    A_RAW     = 4'hA,
    A_RAW_CLR = 4'hB
  } reg_addr_e;

  typedef struct packed {
    logic arm;        // bit 2
    logic reload_en;  // bit 1
    logic run;        // bit 0
  } ctrl_t;

endpackage

// File: rtl/alarm_timer64_core.sv
module alarm_timer64_core #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_i,
  input  logic                tick_i,
  input  logic                arm_i,
  input  logic                reload_en_i,
  input  logic [2*DATA_W-1:0] alarm_i,
  input  logic [2*DATA_W-1:0] reload_i,
  input  logic                snap_req_i,
  output logic                fire_o,
  output logic [2*DATA_W-1:0] snap_o
);
  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] snap_q, snap_d;
  logic             step;

  assign step   = run_i && tick_i;
  assign fire_o = arm_i && (cnt_q >= alarm_i);

  always_comb begin
    cnt_d = cnt_q;
    if (fire_o && reload_en_i) begin
      cnt_d = reload_i;
    end else if (step) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_comb begin
    snap_d = snap_q;
    if (snap_req_i) begin
      snap_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      snap_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      snap_q <= snap_d;
    end
  end

  assign snap_o = snap_q;

  // R1: qualified tick advances the count by one
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick_i && !fire_o) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R1: no qualified tick and no firing leaves the count alone
  p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!(run_i && tick_i) && !fire_o) |=> $stable(cnt_q));

  // R6: reload lands on the firing edge
  p_reload_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && reload_en_i) |=> (cnt_q == $past(reload_i)));

  // R2: snapshot captures the live count on a trigger
  p_snap_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req_i |=> (snap_q == $past(cnt_q)));

  // R2: snapshot holds between triggers
  p_snap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_req_i |=> $stable(snap_q));

endmodule

// File: rtl/alarm_timer64_irq.sv
module alarm_timer64_irq #(
  parameter int IRQ_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic [IRQ_W-1:0] clr_i,
  input  logic [IRQ_W-1:0] ien_i,
  output logic [IRQ_W-1:0] raw_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] raw_q, raw_d, set_vec;

  // bit 0 is the alarm source
  assign set_vec = IRQ_W'(fire_i);

  always_comb begin
    raw_d = (raw_q & ~clr_i) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else begin
      raw_q <= raw_d;
    end
  end

  assign raw_o = raw_q;
  assign irq_o = |(raw_q & ien_i);

  // R7: firing sets raw bit 0
  p_raw_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> raw_q[0]);

  // R7: raw bit is sticky until cleared
  p_raw_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q[0] && !clr_i[0]) |=> raw_q[0]);

  // R8: a clear without a simultaneous set drops the bit
  p_raw_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i[0] && !fire_i) |=> !raw_q[0]);

endmodule

// File: rtl/alarm_timer64_regs.sv
module alarm_timer64_regs
  import alarm_timer64_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                fire_i,
  input  logic [2*DATA_W-1:0] snap_i,
  input  logic [IRQ_W-1:0]    raw_i,
  output ctrl_t               ctrl_o,
  output logic [2*DATA_W-1:0] alarm_o,
  output logic [2*DATA_W-1:0] reload_o,
  output logic [IRQ_W-1:0]    ien_o,
  output logic                snap_req_o,
  output logic [IRQ_W-1:0]    clr_o,
  output logic [DATA_W-1:0]   rdata_o
);
  localparam int CNT_W = 2 * DATA_W;

  ctrl_t             ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  alarm_q, alarm_d;
  logic [CNT_W-1:0]  reload_q, reload_d;
  logic [IRQ_W-1:0]  ien_q, ien_d;
  reg_addr_e         sel;
  logic              ctrl_wr;

  assign sel     = reg_addr_e'(addr_i);
  assign ctrl_wr = wr_i && (sel == A_CTRL);

  always_comb begin
    ctrl_d   = ctrl_q;
    alarm_d  = alarm_q;
    reload_d = reload_q;
    ien_d    = ien_q;
    if (fire_i) begin
      ctrl_d.arm = 1'b0;
    end
    if (wr_i) begin
      case (sel)
        A_CTRL:    ctrl_d = ctrl_t'(wdata_i[2:0]);
        A_ALM_LO:  alarm_d[DATA_W-1:0]      = wdata_i;
        A_ALM_HI:  alarm_d[CNT_W-1:DATA_W]  = wdata_i;
        A_RLD_LO:  reload_d[DATA_W-1:0]     = wdata_i;
        A_RLD_HI:  reload_d[CNT_W-1:DATA_W] = wdata_i;
        A_IEN_SET: ien_d = ien_q | wdata_i[IRQ_W-1:0];
        A_IEN_CLR: ien_d = ien_q & ~wdata_i[IRQ_W-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      alarm_q  <= '0;
      reload_q <= '0;
      ien_q    <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      alarm_q  <= alarm_d;
      reload_q <= reload_d;
      ien_q    <= ien_d;
    end
  end

  assign snap_req_o = wr_i && (sel == A_SNAP);
  assign clr_o      = (wr_i && (sel == A_RAW_CLR)) ? wdata_i[IRQ_W-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    case (sel)
      A_CTRL:    rdata_o[2:0] = ctrl_q;
      A_SNAP_LO: rdata_o = snap_i[DATA_W-1:0];
      A_SNAP_HI: rdata_o = snap_i[CNT_W-1:DATA_W];
      A_ALM_LO:  rdata_o = alarm_q[DATA_W-1:0];
      A_ALM_HI:  rdata_o = alarm_q[CNT_W-1:DATA_W];
      A_RLD_LO:  rdata_o = reload_q[DATA_W-1:0];
      A_RLD_HI:  rdata_o = reload_q[CNT_W-1:DATA_W];
      A_IEN_SET: rdata_o[IRQ_W-1:0] = ien_q;
      A_RAW:     rdata_o[IRQ_W-1:0] = raw_i;
      default:   rdata_o = '0;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign alarm_o  = alarm_q;
  assign reload_o = reload_q;
  assign ien_o    = ien_q;

  // R5: firing disarms unless software rewrites control in that cycle
  p_one_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !ctrl_wr) |=> !ctrl_q.arm);

  // R9: mask-set write leaves every written bit enabled
  p_ien_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel == A_IEN_SET) |=>
      ((ien_q & $past(wdata_i[IRQ_W-1:0])) == $past(wdata_i[IRQ_W-1:0])));

  // R9: mask-clear write removes every written bit
  p_ien_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel == A_IEN_CLR) |=> ((ien_q & $past(wdata_i[IRQ_W-1:0])) == '0));

endmodule

// File: rtl/alarm_timer64.sv
module alarm_timer64
  import alarm_timer64_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;

  logic             rst_meta_q, rst_sync_n;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] alarm_val, reload_val, snap_val;
  logic [IRQ_W-1:0] ien, raw, clr;
  logic             snap_req, fire;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  alarm_timer64_regs #(.DATA_W(DATA_W), .IRQ_W(IRQ_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_i       (bus_wr),
    .addr_i     (bus_addr),
    .wdata_i    (bus_wdata),
    .fire_i     (fire),
    .snap_i     (snap_val),
    .raw_i      (raw),
    .ctrl_o     (ctrl),
    .alarm_o    (alarm_val),
    .reload_o   (reload_val),
    .ien_o      (ien),
    .snap_req_o (snap_req),
    .clr_o      (clr),
    .rdata_o    (bus_rdata)
  );

  alarm_timer64_core #(.DATA_W(DATA_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .run_i       (ctrl.run),
    .tick_i      (tick_en),
    .arm_i       (ctrl.arm),
    .reload_en_i (ctrl.reload_en),
    .alarm_i     (alarm_val),
    .reload_i    (reload_val),
    .snap_req_i  (snap_req),
    .fire_o      (fire),
    .snap_o      (snap_val)
  );

  alarm_timer64_irq #(.IRQ_W(IRQ_W)) u_irq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .fire_i (fire),
    .clr_i  (clr),
    .ien_i  (ien),
    .raw_o  (raw),
    .irq_o  (irq)
  );

endmodule

// File: tb/alarm_timer64_tb.sv
`timescale 1ns/1ps
module alarm_timer64_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  alarm_timer64 u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic snap64(output logic [63:0] v);
    logic [31:0] lo, hi;
    wr_reg(4'h1, 32'h1);
    rd_reg(4'h2, lo);
    rd_reg(4'h3, hi);
    v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    logic [63:0] v;
    rd_reg(4'h0, d); check("R10 ctrl after reset", d, 0);
    rd_reg(4'h8, d); check("R10 mask after reset", d, 0);
    rd_reg(4'hA, d); check("R10 raw after reset", d, 0);
    rd_reg(4'h6, d); check("R6 reload low reset 0", d, 0);
    rd_reg(4'h5, d); check("R10 alarm high after reset", d, 0);
    check("R10 irq after reset", irq, 0);
    snap64(v); check("R10 count after reset", v, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr_reg(4'h4, 32'hDEAD_BEEF);
    wr_reg(4'h5, 32'h1234_5678);
    wr_reg(4'h6, 32'hA5A5_0001);
    wr_reg(4'h7, 32'h0F0F_F0F0);
    rd_reg(4'h4, d); check("R3 alarm low", d, 32'hDEAD_BEEF);
    rd_reg(4'h5, d); check("R3 alarm high", d, 32'h1234_5678);
    rd_reg(4'h6, d); check("R6 reload low", d, 32'hA5A5_0001);
    rd_reg(4'h7, d); check("R6 reload high", d, 32'h0F0F_F0F0);
    wr_reg(4'h0, 32'hFFFF_FFF6);   // arm + reload, run 0; alarm far above count
    rd_reg(4'h0, d); check("R4 ctrl readback", d, 32'h6);
    wr_reg(4'h0, 32'h0);
    rd_reg(4'h0, d); check("R4 ctrl cleared", d, 32'h0);
  endtask

  task automatic t_count;
    logic [63:0] v;
    logic [31:0] d;
    wr_reg(4'h0, 32'h1);
    ticks(7);
    snap64(v); check("R1 seven ticks", v, 7);
    repeat (5) @(negedge clk);
    snap64(v); check("R1 hold with tick_en low", v, 7);
    wr_reg(4'h0, 32'h0);
    ticks(4);
    snap64(v); check("R1 hold with run low", v, 7);
    wr_reg(4'h0, 32'h1);
    ticks(3);
    rd_reg(4'h2, d); check("R2 snapshot holds while counting", d, 7);
    snap64(v); check("R2 new snapshot", v, 10);
  endtask

  task automatic t_alarm_oneshot;
    logic [63:0] v;
    logic [31:0] d;
    wr_reg(4'h5, 32'h0);
    wr_reg(4'h4, 32'd15);
    wr_reg(4'h0, 32'h5);            // arm + run, count = 10
    rd_reg(4'hA, d); check("R5 no fire below alarm", d, 0);
    ticks(10);
    snap64(v); check("R5 no reload keeps counting", v, 20);
    rd_reg(4'h0, d); check("R5 arm cleared after firing", d, 32'h1);
    rd_reg(4'hA, d); check("R7 raw set by alarm", d, 1);
    check("R9 irq low with mask 0", irq, 0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr_reg(4'h8, 32'h0);
    rd_reg(4'h8, d); check("R9 mask set with 0", d, 0);
    check("R9 irq still low", irq, 0);
    wr_reg(4'h8, 32'h1);
    rd_reg(4'h8, d); check("R9 mask set", d, 1);
    check("R9 irq high", irq, 1);
    wr_reg(4'hB, 32'h0);
    rd_reg(4'hA, d); check("R8 clear with 0 keeps bit", d, 1);
    wr_reg(4'h9, 32'h1);
    rd_reg(4'h8, d); check("R9 mask cleared", d, 0);
    check("R9 irq low after mask clear", irq, 0);
    rd_reg(4'hA, d); check("R7 raw sticky under mask", d, 1);
    wr_reg(4'h8, 32'h1);
    check("R9 irq back high", irq, 1);
    wr_reg(4'hB, 32'h1);
    rd_reg(4'hA, d); check("R8 clear with 1", d, 0);
    check("R9 irq low after clear", irq, 0);
  endtask

  task automatic t_reload;
    logic [63:0] v;
    logic [31:0] d;
    wr_reg(4'h7, 32'h0);
    wr_reg(4'h6, 32'd100);
    wr_reg(4'h4, 32'd25);            // count = 20
    wr_reg(4'h0, 32'h7);
    ticks(10);                        // 25 after 5 edges, reload on 6th, +4
    snap64(v); check("R6 reload on firing edge", v, 104);
    rd_reg(4'hA, d); check("R7 raw after reload fire", d, 1);
    check("R9 irq after reload fire", irq, 1);
    wr_reg(4'hB, 32'h1);
  endtask

  task automatic t_carry;
    logic [63:0] v;
    logic [31:0] d;
    wr_reg(4'h0, 32'h0);
    wr_reg(4'h6, 32'hFFFF_FFFE);
    wr_reg(4'h4, 32'h0);
    wr_reg(4'h0, 32'h6);             // arm + reload, alarm 0 already passed
    repeat (2) @(negedge clk);
    snap64(v); check("R6 reload of 64-bit value", v, 64'h0000_0000_FFFF_FFFE);
    rd_reg(4'h0, d); check("R5 fired with count past alarm", d, 32'h2);
    wr_reg(4'h0, 32'h3);
    ticks(3);
    snap64(v); check("R1 carry into high word", v, 64'h0000_0001_0000_0001);
    wr_reg(4'hB, 32'h1);
  endtask

  task automatic t_past_no_reload;
    logic [63:0] v;
    logic [31:0] d;
    wr_reg(4'h0, 32'h0);
    wr_reg(4'h5, 32'h0);
    wr_reg(4'h4, 32'd5);
    wr_reg(4'h0, 32'h5);             // arm + run, tick_en low
    repeat (2) @(negedge clk);
    rd_reg(4'hA, d); check("R5 immediate fire when past", d, 1);
    rd_reg(4'h0, d); check("R5 disarmed", d, 32'h1);
    snap64(v); check("R6 no reload leaves count", v, 64'h0000_0001_0000_0001);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_count();
    t_alarm_oneshot();
    t_irq();
    t_reload();
    t_carry();
    t_past_no_reload();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule